// File: doc/BRIEF.md
# End-Referenced Dual-Modulus Prescaler Controller

This block sits behind an external dual-modulus prescaler, a divider that divides the oscillator by either P or P+1. It produces the divided feedback edge that goes to the phase detector. It runs on the prescaler's output clock. It counts prescaler output cycles with a single down counter, so each divide cycle spans M prescaler cycles. For the last A of those cycles it asks the prescaler for the larger modulus. A divide cycle therefore holds exactly P·M + A oscillator cycles. The requested divide word N is split as M = N / P and A = N mod P. P is a power of two, so M is the upper bits of N and A is the low log2(P) bits.

The larger modulus is placed at the end of each divide cycle. The start of the cycle, where the feedback edge lies, therefore sees no modulus switching. In the last cycle of each divide cycle a strobe tells the fractional controller that a new word is taken at the end of that cycle. If no valid word is offered then, the previous word is used again. Words that cannot be divided this way are clamped to the nearest legal value and flagged. A word is illegal when M is zero or when A is larger than M.

Top module: `endref_prescale_ctl`

## Requirements
- R1: While `rst` is high, `mod_hi`, `div_edge`, `reload` and `cfg_err` are low. The first divide cycle after reset uses `div_word` if `div_valid` is high in the first cycle after reset. Otherwise it uses the parameter `RST_WORD`.
- R2: A divide cycle lasts M prescaler cycles, from one `div_edge` pulse up to the cycle before the next. M = `div_word[NW-1:PW]`, with PW = log2(P).
- R3: In each divide cycle `mod_hi` is high for exactly A consecutive cycles, and the last of them is the cycle with `reload`. A = `div_word[PW-1:0]`. When A equals M, `mod_hi` is high for the whole cycle.
- R4: When A is less than M, `mod_hi` is low in the cycle with `div_edge`. `mod_hi` only falls in the first cycle of a divide cycle.
- R5: `div_edge` is high for exactly the first cycle of each divide cycle. It follows every `reload` cycle by one cycle.
- R6: `reload` is high in exactly the last cycle of each divide cycle. `div_word` is taken at the clock edge that ends that cycle if `div_valid` is high there.
- R7: If `div_valid` is low at the end of the `reload` cycle, the previous word is used again. A `div_valid` pulse in any other cycle has no effect.
- R8: A word with M = 0 is run with M = 1, and `cfg_err` is high throughout that divide cycle.
- R9: A word with A > M is run with A = M, and `cfg_err` is high throughout that divide cycle. For a legal word `cfg_err` is low.
- R10: Within a divide cycle the internal count drops by exactly one per prescaler cycle, down to one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| div_word | input | NW | Requested divide value N |
| div_valid | input | 1 | `div_word` holds a new value |
| mod_hi | output | 1 | High requests modulus P+1 from the prescaler |
| div_edge | output | 1 | One-cycle pulse that starts each divide cycle |
| reload | output | 1 | Last cycle of the divide cycle; the word is taken at its end |
| cfg_err | output | 1 | The current divide cycle runs a clamped word |

## Verification
The divider is driven with a sequence of words. A long word with a small swallow count shows the counting length and that the high-modulus run sits at the end rather than the start. A word with A equal to M tells a full-cycle high run apart from an off-by-one start. A word with A of zero shows that the request never rises. Words with M of one put the edge, the request and the strobe in the same cycle. A divide cycle with no valid word, plus a valid pulse in the middle of a cycle, separates sampling at the strobe from sampling at any time. Two illegal words, one with M of zero and one with A greater than M, show the two clamps apart from a legal word that follows them.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
  // Registered output flags of the controller
  typedef struct packed {
    logic edge_p;
    logic hi_req;
    logic strobe;
    logic clamp;
  } ndiv_flags_t;
endpackage

// File: rtl/ndiv_hold.sv
// Keeps the divide word in use; takes a new one only at terminal count
module ndiv_hold #(
  parameter int NW = 16,
  parameter logic [NW-1:0] RST_WORD = 16'd1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          term,
  input  logic [NW-1:0] word_in,
  input  logic          word_vld,
  output logic [NW-1:0] word_sel
);
  logic [NW-1:0] hold_q;

  assign word_sel = (term && word_vld) ? word_in : hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= RST_WORD;
    else if (term) hold_q <= word_sel;
  end
endmodule

// File: rtl/ndiv_split.sv
// Splits N into the count M and the swallow A, clamping illegal pairs
module ndiv_split #(
  parameter int NW = 16,
  parameter int PW = 5,
  localparam int CW = NW - PW
) (
  input  logic [NW-1:0] word,
  output logic [CW-1:0] m_cnt,
  output logic [CW-1:0] a_cnt,
  output logic          bad
);
  logic [CW-1:0] m_raw;
  logic [CW-1:0] a_raw;
  logic          m_zero;
  logic          a_over;

  assign m_raw  = word[NW-1:PW];
  assign a_raw  = {{(CW-PW){1'b0}}, word[PW-1:0]};
  assign m_zero = (m_raw == '0);

  always_comb begin
    m_cnt  = m_zero ? CW'(1) : m_raw;
    a_over = (a_raw > m_cnt);
    a_cnt  = a_over ? m_cnt : a_raw;
    bad    = m_zero || a_over;
  end
endmodule

// File: rtl/ndiv_count.sv
// Single down counter; terminal count at one (or zero straight after reset)
module ndiv_count #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] m_load,
  input  logic [CW-1:0] a_load,
  output logic          term,
  output logic [CW-1:0] cnt_nx,
  output logic [CW-1:0] a_nx,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] a_q;

  assign term = (cnt_q <= CW'(1));

  always_comb begin
    if (term) begin
      cnt_nx = m_load;
      a_nx   = a_load;
    end else begin
      cnt_nx = cnt_q - CW'(1);
      a_nx   = a_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      a_q   <= '0;
    end else begin
      cnt_q <= cnt_nx;
      a_q   <= a_nx;
    end
  end
endmodule

// File: rtl/ndiv_modctl.sv
// Comparator against the swallow count and the registered output flags
module ndiv_modctl
  import ndiv_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          term,
  input  logic          bad,
  input  logic [CW-1:0] cnt_nx,
  input  logic [CW-1:0] a_nx,
  output ndiv_flags_t   flags
);
  ndiv_flags_t flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      flags_q.edge_p <= term;
      flags_q.hi_req <= (cnt_nx <= a_nx);
      flags_q.strobe <= (cnt_nx == CW'(1));
      if (term) flags_q.clamp <= bad;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/endref_prescale_ctl.sv
module endref_prescale_ctl
  import ndiv_pkg::*;
#(
  parameter int P  = 32,
  parameter int NW = 16,
  parameter logic [NW-1:0] RST_WORD = 16'd1000
) (
  input  logic          clk_pre,
  input  logic          rst,
  input  logic [NW-1:0] div_word,
  input  logic          div_valid,
  output logic          mod_hi,
  output logic          div_edge,
  output logic          reload,
  output logic          cfg_err
);
  // P must be a power of two and NW must exceed 2*log2(P)
  localparam int PW = $clog2(P);
  localparam int CW = NW - PW;

  logic          term;
  logic          bad;
  logic [NW-1:0] word_sel;
  logic [CW-1:0] m_cnt;
  logic [CW-1:0] a_cnt;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] a_nx;
  logic [CW-1:0] cnt_q;
  ndiv_flags_t   flags;

  ndiv_hold #(.NW(NW), .RST_WORD(RST_WORD)) hold_i (
    .clk(clk_pre), .rst(rst), .term(term),
    .word_in(div_word), .word_vld(div_valid), .word_sel(word_sel)
  );

  ndiv_split #(.NW(NW), .PW(PW)) split_i (
    .word(word_sel), .m_cnt(m_cnt), .a_cnt(a_cnt), .bad(bad)
  );

  ndiv_count #(.CW(CW)) count_i (
    .clk(clk_pre), .rst(rst), .m_load(m_cnt), .a_load(a_cnt),
    .term(term), .cnt_nx(cnt_nx), .a_nx(a_nx), .cnt_q(cnt_q)
  );

  ndiv_modctl #(.CW(CW)) modctl_i (
    .clk(clk_pre), .rst(rst), .term(term), .bad(bad),
    .cnt_nx(cnt_nx), .a_nx(a_nx), .flags(flags)
  );

  assign div_edge = flags.edge_p;
  assign mod_hi   = flags.hi_req;
  assign reload   = flags.strobe;
  assign cfg_err  = flags.clamp;
endmodule

// File: rtl/endref_prescale_ctl_chk.sv
module endref_prescale_ctl_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic          mod_hi,
  input logic          div_edge,
  input logic          reload
);
  // R6
  reload_term_chk: assert property (@(posedge clk) disable iff (rst)
    reload |-> (cnt == CW'(1)));

  // R5
  edge_follow_chk: assert property (@(posedge clk) disable iff (rst)
    reload |=> div_edge);

  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_hi && !reload) |=> mod_hi);

  // R4
  hi_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mod_hi) |-> div_edge);

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt > CW'(1)) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

bind endref_prescale_ctl endref_prescale_ctl_chk #(.CW(CW)) chk_i (
  .clk(clk_pre), .rst(rst), .cnt(cnt_q),
  .mod_hi(mod_hi), .div_edge(div_edge), .reload(reload)
);

// File: tb/endref_prescale_ctl_tb_top.sv
`timescale 1ns/1ps
module endref_prescale_ctl_tb_top;
  localparam int P  = 32;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] div_word = '0;
  logic          div_valid = 1'b0;
  logic          mod_hi, div_edge, reload, cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  endref_prescale_ctl #(.P(P), .NW(NW), .RST_WORD(16'd1000)) dut_i (
    .clk_pre(clk), .rst(rst), .div_word(div_word), .div_valid(div_valid),
    .mod_hi(mod_hi), .div_edge(div_edge), .reload(reload), .cfg_err(cfg_err)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Observes one divide cycle, starting at a negedge where it begins.
  // Offers nxt_word with nxt_vld in the reload cycle; glitch drives a
  // stray valid pulse in the second cycle.
  task automatic observe(input int m, input int a, input int er,
                         input logic [NW-1:0] nxt_word, input bit nxt_vld,
                         input bit glitch, input string tag);
    int len = 0;
    int highs = 0;
    int shape_bad = 0;
    int err_bad = 0;
    bit fin = 0;
    chk(div_edge, 1, {tag, " R5 edge at start"});
    while (!fin && len < 4096) begin
      if (glitch && len == 1) begin
        div_valid = 1'b1;
        div_word  = 16'd777;
      end
      if (glitch && len == 2) div_valid = 1'b0;
      if (mod_hi) highs++;
      if (mod_hi != (len >= m - a)) shape_bad++;
      if (div_edge != (len == 0)) shape_bad++;
      if (cfg_err != er[0]) err_bad++;
      if (reload) begin
        fin = 1;
        div_word  = nxt_word;
        div_valid = nxt_vld;
      end
      len++;
      @(negedge clk);
    end
    div_valid = 1'b0;
    chk(len, m, {tag, " R2 R6 cycle length"});
    chk(highs, a, {tag, " R3 high count"});
    chk(shape_bad, 0, {tag, " R3 R4 R5 placement"});
    chk(err_bad, 0, {tag, " R8 R9 error flag"});
    chk(div_edge, 1, {tag, " R5 next edge"});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(mod_hi, 0, "R1 reset mod_hi");
    chk(div_edge, 0, "R1 reset div_edge");
    chk(reload, 0, "R1 reset reload");
    chk(cfg_err, 0, "R1 reset cfg_err");
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    // R1 default word 1000 = 31*32+8
    observe(31, 8, 0, 16'd163, 1, 0, "R1 default");
    // R6 word 163 = 5*32+3, next A==M
    observe(5, 3, 0, 16'd132, 1, 0, "R6 taken");
    // R3 A==M: 132 = 4*32+4, next no valid
    observe(4, 4, 0, 16'd9, 0, 0, "R3 full high");
    // R7 reuse, stray valid mid-cycle ignored
    observe(4, 4, 0, 16'd96, 1, 1, "R7 reuse");
    // R4 A=0: 96 = 3*32
    observe(3, 0, 0, 16'd33, 1, 0, "R4 no swallow");
    // M=1 A=1: 33
    observe(1, 1, 0, 16'd5, 1, 0, "R2 single");
    // R8 M=0 A=5 -> M=1 A=1
    observe(1, 1, 1, 16'd71, 1, 0, "R8 clamp M");
    // R9 71 = 2*32+7 -> A=2
    observe(2, 2, 1, 16'd194, 1, 0, "R9 clamp A");
    // R9 legal 194 = 6*32+2
    observe(6, 2, 0, 16'd194, 0, 0, "R9 legal");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule